// File: doc/BRIEF.md
# Serial Binary Gap Finder

This block accepts a 32-bit unsigned word on a one-cycle start pulse and walks through it one bit per clock, starting from the least significant end. As it walks, it finds the longest spacing between two neighbouring set bits. Two set bits count as neighbours when only zeros lie between them. The spacing is the difference of their bit positions.

The walk ends as soon as the bits still left to examine are all zero. Short words therefore finish early, and wide words take at most 33 cycles after the start edge. The finished spacing comes out on a registered 6-bit output together with a done flag. Both stay in place until the next accepted start. A start that arrives while a walk is in progress is dropped.

Top module: `binary_gap_scan`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o` and `gap_o` are all 0.
- R2: The reported spacing of two neighbouring set bits is the difference of their positions, so binary 1001 gives 3 and binary 11 gives 1.
- R3: Zeros below the lowest set bit count toward no spacing, so 68 (binary 1000100) gives 4 and not 6.
- R4: With several neighbouring pairs, the largest spacing is reported: 22 gives 2, 5 gives 2, 6 gives 1, 262 gives 6, 4102 gives 10.
- R5: A word with exactly one set bit gives 0 (8, 1024 and 1 each give 0).
- R6: An all-zero word sets `done_o` on the first clock edge after the edge that sampled start, with `gap_o` equal to 0.
- R7: For a nonzero word whose highest set bit is at index p, `done_o` rises on the (p+2)-th edge after the start edge, and `busy_o` is high until then. The bound is 33 edges.
- R8: `done_o` and `gap_o` hold their values until the next start. An accepted start clears `done_o` on its edge.
- R9: A start pulse while `busy_o` is high is ignored: the walk in progress finishes with its own result and its own timing.
- R10: Words that use the top bit work: 0x80000001 gives 31 and 0xFFFFFFFF gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, sampled when not busy |
| value_i | input | 32 | Word to scan, captured with the start |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | Result valid, held until the next start |
| gap_o | output | 6 | Largest spacing between neighbouring set bits |

## Verification
For every word, the bench finds the index of the highest set bit and from it computes the edge on which `done_o` must rise: one edge after the start edge for zero, and p+2 edges for a nonzero word. It counts edges from the start edge and samples on falling edges. It checks that `done_o` stays low and `busy_o` stays high before the due edge, that both outputs change on that edge, and that `gap_o` then equals a bench model of position differences. Held results are sampled several cycles later. After a new start, the bench checks `done_o` one edge after that start. For a start sent during a walk, the bench checks the latency and result of the first word.

// File: rtl/bgap_pkg.sv
package bgap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } scan_state_t;

endpackage

// File: rtl/bgap_shifter.sv
module bgap_shifter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic              lsb_o,
  output logic              empty_o
);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= load_val_i;
    end else if (shift_i) begin
      sh_q <= {1'b0, sh_q[DATA_W-1:1]};
    end
  end

  assign lsb_o   = sh_q[0];
  assign empty_o = (sh_q == '0);

  // R7: a shift never adds set bits, so the walk always drains
  p_shift_drains_r7: assert property (@(posedge clk) disable iff (rst)
    shift_i && !load_i |=> $countones(sh_q) <= $countones($past(sh_q)));

endmodule

// File: rtl/bgap_tracker.sv
module bgap_tracker #(
  parameter int RES_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [RES_W-1:0] best_o
);

  logic             seen_q;
  logic [RES_W-1:0] run_q;
  logic [RES_W-1:0] best_q;
  logic [RES_W-1:0] cand;

  assign cand = run_q + RES_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      seen_q <= 1'b0;
      run_q  <= '0;
      best_q <= '0;
    end else if (step_i) begin
      if (bit_i) begin
        if (seen_q && (cand > best_q)) begin
          best_q <= cand;
        end
        seen_q <= 1'b1;
        run_q  <= '0;
      end else if (seen_q) begin
        run_q <= run_q + RES_W'(1);
      end
    end
  end

  assign best_o = best_q;

  // R4: the best spacing only ever grows during a walk
  p_best_grows_r4: assert property (@(posedge clk) disable iff (rst)
    step_i && !clear_i |=> best_q >= $past(best_q));

  // R2: a set bit restarts the running spacing
  p_run_restart_r2: assert property (@(posedge clk) disable iff (rst)
    step_i && bit_i && !clear_i |=> run_q == '0);

  // R3: no spacing accumulates before the first set bit
  p_no_lead_count_r3: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> run_q == '0 && best_q == '0);

endmodule

// File: rtl/bgap_ctrl.sv
module bgap_ctrl
  import bgap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic empty_i,
  output logic load_o,
  output logic step_o,
  output logic capture_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(DATA_W + 2) + 1;

  scan_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_SCAN;
      ST_SCAN: if (empty_i) state_d = ST_DONE;
      ST_DONE: if (start_i) state_d = ST_SCAN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign load_o    = (state_q != ST_SCAN) && start_i;
  assign step_o    = (state_q == ST_SCAN) && !empty_i;
  assign capture_o = (state_q == ST_SCAN) && empty_i;
  assign busy_o    = (state_q == ST_SCAN);
  assign done_o    = (state_q == ST_DONE);

  // Watch counter for the latency bound; checker logic only
  logic [CNT_W-1:0] scan_cnt_q;
  always_ff @(posedge clk) begin
    if (rst || state_q != ST_SCAN) scan_cnt_q <= '0;
    else                           scan_cnt_q <= scan_cnt_q + CNT_W'(1);
  end

  // R7: a walk never lasts beyond DATA_W+1 scanning cycles
  p_latency_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> scan_cnt_q <= CNT_W'(DATA_W));

  // R7: an empty remainder finishes the walk on the next edge
  p_empty_ends_r7: assert property (@(posedge clk) disable iff (rst)
    busy_o && empty_i |=> done_o && !busy_o);

  // R9: a start during a walk does not restart or end it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o && start_i && !empty_i |=> busy_o);

endmodule

// File: rtl/binary_gap_scan.sv
module binary_gap_scan #(
  parameter int DATA_W = 32,
  parameter int RES_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] value_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  gap_o
);

  logic             load, step, capture, lsb, empty;
  logic [RES_W-1:0] best;
  logic [RES_W-1:0] gap_q;

  bgap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .empty_i   (empty),
    .load_o    (load),
    .step_o    (step),
    .capture_o (capture),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  bgap_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .shift_i    (step),
    .load_val_i (value_i),
    .lsb_o      (lsb),
    .empty_o    (empty)
  );

  bgap_tracker #(.RES_W(RES_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .clear_i (load),
    .step_i  (step),
    .bit_i   (lsb),
    .best_o  (best)
  );

  always_ff @(posedge clk) begin
    if (rst)          gap_q <= '0;
    else if (capture) gap_q <= best;
  end

  assign gap_o = gap_q;

  // R1: never busy and done at once
  p_busy_done_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R8: result held while no new start arrives
  p_hold_result_r8: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o && $stable(gap_o));

  // R8: an accepted start clears done on its edge
  p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
    done_o && start_i |=> !done_o && busy_o);

  // R10: result never exceeds the largest possible spacing
  p_gap_range_r10: assert property (@(posedge clk) disable iff (rst)
    gap_o <= RES_W'(DATA_W - 1));

endmodule

// File: tb/tb_binary_gap_scan.sv
module tb_binary_gap_scan;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] value_i = '0;
  logic        busy_o, done_o;
  logic [5:0]  gap_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  binary_gap_scan dut (
    .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i),
    .busy_o(busy_o), .done_o(done_o), .gap_o(gap_o)
  );

  function automatic int ref_gap(input logic [31:0] v);
    int last = -1;
    int best = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) begin
        if (last >= 0 && (i - last) > best) best = i - last;
        last = i;
      end
    end
    return best;
  endfunction

  function automatic int ref_lat(input logic [31:0] v);
    int top = -1;
    for (int i = 0; i < 32; i++) if (v[i]) top = i;
    return (top < 0) ? 1 : top + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one word; optional second start sent mid-walk (R9)
  task automatic run(input logic [31:0] v, input string req,
                     input bit intrude, input logic [31:0] v2);
    int n = 0;
    int lat = ref_lat(v);
    bit early = 0;
    @(negedge clk);
    value_i = v; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o, "R8 start clears done", done_o, 0);
    while (n < 40) begin
      if (intrude && n == 2) begin value_i = v2; start_i = 1'b1; end
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      n++;
      if (done_o) break;
      if (!busy_o) early = 1;
    end
    check(!early, "R7 busy during walk", early, 0);
    check(n == lat, {req, " latency"}, n, lat);
    check(done_o && !busy_o, {req, " done"}, done_o, 1);
    check(gap_o == ref_gap(v), {req, " gap"}, gap_o, ref_gap(v));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] held;
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && gap_o == 0, "R1 reset", {busy_o, done_o, gap_o}, 0);

    run(32'b1001, "R2", 0, 0);
    run(32'b11, "R2", 0, 0);
    run(32'd68, "R3", 0, 0);
    run(32'd22, "R4", 0, 0);
    run(32'd5, "R4", 0, 0);
    run(32'd6, "R4", 0, 0);
    run(32'd262, "R4", 0, 0);
    run(32'd4102, "R4", 0, 0);
    run(32'd8, "R5", 0, 0);
    run(32'd1024, "R5", 0, 0);
    run(32'd1, "R5", 0, 0);
    run(32'd0, "R6", 0, 0);
    run(32'h8000_0001, "R10", 0, 0);
    run(32'hFFFF_FFFF, "R10", 0, 0);
    run(32'h8000_0000, "R7", 0, 0);

    // R8: result held for several idle cycles
    held = gap_o;
    repeat (5) @(negedge clk);
    check(done_o && gap_o == held, "R8 hold", gap_o, held);

    // R9: second start during walk is dropped
    run(32'h0004_0011, "R9", 1, 32'h0000_0003);
    run(32'h0000_0000, "R9 zero", 0, 0);

    for (int k = 0; k < 300; k++) begin
      logic [31:0] r = $urandom();
      if (k % 3 == 1) r = r & $urandom() & $urandom();
      if (k % 3 == 2) r = r >> ($urandom() % 32);
      run(r, "R4 random", 0, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule